// File: doc/BRIEF.md
# Cascadable Dual Pixel FIFO

This block buffers 32-bit display words between a memory-side bus clock and a pixel clock. It holds two storage banks of 16 words each. In dual-panel mode each bank is an independent FIFO serving one panel. In single-panel (cascade) mode the two banks form one 32-entry FIFO. The bus-side writer fills the FIFOs, and each FIFO raises a space flag whenever at least four entries are free. The pixel-side unpacker pulls one word at a time through a toggle handshake that crosses into the bus clock and back.

A read that finds its FIFO empty returns no data. Instead it sets a sticky underflow interrupt in the pixel domain, which stays set until it is cleared explicitly. The cascade mode is sampled only while the flush input is high. Flush also empties both FIFOs, so the mode can never change while data is stored under the old layout.

Top module: `dual_pixel_fifo`

## Requirements
- R1: In dual mode (`rdPanel`/`wrPanel` 0 selects FIFO 0, 1 selects FIFO 1), each FIFO holds up to 16 words and returns its own words in write order, independent of the other FIFO.
- R2: In cascade mode one 32-entry FIFO returns words in write order across both banks, and `wrPanel` and `rdPanel` are ignored.
- R3: A write to a full FIFO (16 words in dual mode, 32 words in cascade mode) is dropped and does not disturb the stored words.
- R4: `spaceReq[i]` (bit 0 for FIFO 0, bit 1 for FIFO 1) is 1 when that FIFO has at least 4 free entries. In cascade mode bit 0 reflects the 32-entry FIFO and bit 1 is 0. After reset both bits are 1.
- R5: A read of an empty FIFO produces no `rdValid` pulse and sets `underflowIrq`, which stays set afterwards. `underflowIrq` is 0 after reset.
- R6: A high `irqClear` on a pixel clock edge clears `underflowIrq`.
- R7: While `flush` is high, both FIFOs are emptied and the mode register loads `cascadeIn` (1 = cascade). At other times `cascadeIn` is ignored. Reset leaves both FIFOs empty in dual mode.
- R8: `rdReq` is taken only when `rdReady` is 1. `rdReady` then stays low until the handshake returns. A successful read gives one single-cycle `rdValid` pulse carrying the word on `rdData`.
- R9: `wrBusy` goes high on the bus clock while a read request is being serviced, and a write offered while it is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Memory-side bus clock |
| busRst_n | input | 1 | Active-low reset, bus domain |
| pixClk | input | 1 | Pixel clock |
| pixRst_n | input | 1 | Active-low reset, pixel domain |
| flush | input | 1 | Empty both FIFOs and load the mode |
| cascadeIn | input | 1 | Requested mode: 1 = one 32-entry FIFO |
| wrEn | input | 1 | Write strobe |
| wrPanel | input | 1 | Target FIFO in dual mode |
| wrData | input | 32 | Word to store |
| spaceReq | output | 2 | Per-FIFO space-available flags |
| wrBusy | output | 1 | Bus side is servicing a read |
| rdReq | input | 1 | Read request, pixel domain |
| rdPanel | input | 1 | Source FIFO in dual mode |
| irqClear | input | 1 | Clear the underflow interrupt |
| rdReady | output | 1 | A new read may be issued |
| rdValid | output | 1 | One-cycle pulse: `rdData` is valid |
| rdData | output | 32 | Word returned to the unpacker |
| underflowIrq | output | 1 | Sticky empty-read interrupt |

## Verification
A write changes the stored count, and so `spaceReq`, at the bus edge where `wrEn` is sampled. The bench therefore reads the flags at the next falling bus edge. A read takes two bus-clock synchronizer stages plus one service cycle, then two pixel-clock synchronizer stages plus one output register, before `rdValid` or `underflowIrq` appears. The read task does not count cycles. It waits for `rdReady` to return and then two more pixel cycles before it checks the interrupt. A monitor compares each `rdValid` word against the scoreboard queue at the falling pixel edge, and a `rdValid` pulse that arrives with no expected word counts as a failure.

// File: rtl/pixfifo_pkg.sv
package pixfifo_pkg;
  localparam int AW = 4;  // log2 of the per-bank depth

  typedef struct packed {
    logic          push;
    logic          pushBank;
    logic [AW-1:0] pushAddr;
    logic          pop;
    logic          popBank;
    logic [AW-1:0] popAddr;
  } strobe_t;
endpackage

// File: rtl/pixfifo_store.sv
module pixfifo_store
  import pixfifo_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           st,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] retData
);
  localparam int DEPTH = 1 << AW;

  logic [1:0][DATA_W-1:0] bankRd;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DATA_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (st.push && st.pushBank == 1'(b)) mem[st.pushAddr] <= wrData;
    end
    assign bankRd[b] = mem[st.popAddr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) retData <= '0;
    else if (st.pop) retData <= bankRd[st.popBank];
  end
endmodule

// File: rtl/pixfifo_ctrl.sv
module pixfifo_ctrl
  import pixfifo_pkg::*;
#(
  parameter int SPACE_MARK = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       cascadeIn,
  input  logic       wrEn,
  input  logic       wrPanel,
  input  logic       reqTogIn,
  input  logic       reqPanelIn,
  output strobe_t    st,
  output logic [1:0] spaceReq,
  output logic       wrBusy,
  output logic       ackTog,
  output logic       retUnder
);
  localparam int DEPTH = 1 << AW;
  localparam int PW = AW + 1;
  localparam int CW = AW + 2;
  localparam logic [CW-1:0] CAP_ONE  = CW'(DEPTH);
  localparam logic [CW-1:0] CAP_BOTH = CW'(2 * DEPTH);
  localparam logic [CW-1:0] MARK     = CW'(SPACE_MARK);

  logic                   modeCas;
  logic [1:0][PW-1:0]     wrPtr, rdPtr;
  logic [1:0][CW-1:0]     count;
  logic                   reqS1, reqS2;
  logic                   pend, pushFifo, popFifo, full, empty, doPush, doPop;
  logic [CW-1:0]          cap0;

  function automatic logic [PW-1:0] bumpPtr(input logic [PW-1:0] p, input logic cas);
    logic [AW-1:0] low;
    low = p[AW-1:0] + AW'(1);
    return cas ? p + PW'(1) : {1'b0, low};
  endfunction

  assign pend     = reqS2 != ackTog;
  assign wrBusy   = pend;
  assign pushFifo = modeCas ? 1'b0 : wrPanel;
  assign popFifo  = modeCas ? 1'b0 : reqPanelIn;
  assign cap0     = modeCas ? CAP_BOTH : CAP_ONE;
  assign full     = count[pushFifo] == (pushFifo ? CAP_ONE : cap0);
  assign empty    = count[popFifo] == '0;
  assign doPush   = wrEn && !pend && !full && !flush;
  assign doPop    = pend && !empty && !flush;

  always_comb begin
    st.push     = doPush;
    st.pushBank = modeCas ? wrPtr[0][AW] : pushFifo;
    st.pushAddr = wrPtr[pushFifo][AW-1:0];
    st.pop      = doPop;
    st.popBank  = modeCas ? rdPtr[0][AW] : popFifo;
    st.popAddr  = rdPtr[popFifo][AW-1:0];
  end

  assign spaceReq[0] = (cap0 - count[0]) >= MARK;
  assign spaceReq[1] = !modeCas && ((CAP_ONE - count[1]) >= MARK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      modeCas  <= 1'b0;
      reqS1    <= 1'b0;
      reqS2    <= 1'b0;
      ackTog   <= 1'b0;
      retUnder <= 1'b0;
    end else begin
      reqS1 <= reqTogIn;
      reqS2 <= reqS1;
      if (pend) begin
        ackTog   <= reqS2;
        retUnder <= !doPop;
      end
      if (flush) begin
        wrPtr   <= '0;
        rdPtr   <= '0;
        count   <= '0;
        modeCas <= cascadeIn;
      end else begin
        if (doPush) wrPtr[pushFifo] <= bumpPtr(wrPtr[pushFifo], modeCas);
        if (doPop)  rdPtr[popFifo]  <= bumpPtr(rdPtr[popFifo], modeCas);
        for (int i = 0; i < 2; i++) begin
          count[i] <= count[i] + CW'(doPush && pushFifo == 1'(i))
                               - CW'(doPop && popFifo == 1'(i));
        end
      end
    end
  end

  // R3: stored count never passes the capacity of the layout
  a_r3_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    count[0] <= cap0 && count[1] <= CAP_ONE);
  // R2: upper bank counter idles while chained
  a_r2_lower_idle: assert property (@(posedge clk) disable iff (!rst_n)
    modeCas |-> count[1] == '0);
  // R7: flush empties both FIFOs
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> count[0] == '0 && count[1] == '0);
  // R7: mode only moves during flush
  a_r7_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> $stable(modeCas));
  // R9: a serviced request is acknowledged in one cycle
  a_r9_busy_ack: assert property (@(posedge clk) disable iff (!rst_n)
    wrBusy |=> !wrBusy);
  // R9: nothing is stored while busy
  a_r9_busy_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    wrBusy && !doPop && !flush |=> $stable(count));
endmodule

// File: rtl/pixfifo_pixside.sv
module pixfifo_pixside #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rdReq,
  input  logic              rdPanel,
  input  logic              irqClear,
  input  logic              ackTogIn,
  input  logic              retUnderIn,
  input  logic [DATA_W-1:0] retDataIn,
  output logic              reqTog,
  output logic              reqPanel,
  output logic              rdReady,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              underflowIrq
);
  logic ackS1, ackS2, ackPrev, ackEvent;

  assign rdReady  = reqTog == ackS2;
  assign ackEvent = ackS2 != ackPrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reqTog       <= 1'b0;
      reqPanel     <= 1'b0;
      ackS1        <= 1'b0;
      ackS2        <= 1'b0;
      ackPrev      <= 1'b0;
      rdValid      <= 1'b0;
      rdData       <= '0;
      underflowIrq <= 1'b0;
    end else begin
      ackS1   <= ackTogIn;
      ackS2   <= ackS1;
      ackPrev <= ackS2;
      if (rdReq && rdReady) begin
        reqTog   <= ~reqTog;
        reqPanel <= rdPanel;
      end
      rdValid <= ackEvent && !retUnderIn;
      if (ackEvent && !retUnderIn) rdData <= retDataIn;
      if (ackEvent && retUnderIn) underflowIrq <= 1'b1;
      else if (irqClear)          underflowIrq <= 1'b0;
    end
  end

  // R5: interrupt holds until cleared
  a_r5_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    underflowIrq && !irqClear |=> underflowIrq);
  // R8: data strobe lasts one cycle
  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rdValid |=> !rdValid);
  // R8: ready drops once a request is taken
  a_r8_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
    rdReq && rdReady |=> !rdReady);
endmodule

// File: rtl/dual_pixel_fifo.sv
module dual_pixel_fifo
  import pixfifo_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int SPACE_MARK = 4
) (
  input  logic              busClk,
  input  logic              busRst_n,
  input  logic              pixClk,
  input  logic              pixRst_n,
  input  logic              flush,
  input  logic              cascadeIn,
  input  logic              wrEn,
  input  logic              wrPanel,
  input  logic [DATA_W-1:0] wrData,
  output logic [1:0]        spaceReq,
  output logic              wrBusy,
  input  logic              rdReq,
  input  logic              rdPanel,
  input  logic              irqClear,
  output logic              rdReady,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              underflowIrq
);
  strobe_t           st;
  logic              reqTog, reqPanel, ackTog, retUnder;
  logic [DATA_W-1:0] retData;

  pixfifo_ctrl #(.SPACE_MARK(SPACE_MARK)) u_ctrl (
    .clk(busClk), .rst_n(busRst_n), .flush(flush), .cascadeIn(cascadeIn),
    .wrEn(wrEn), .wrPanel(wrPanel), .reqTogIn(reqTog), .reqPanelIn(reqPanel),
    .st(st), .spaceReq(spaceReq), .wrBusy(wrBusy), .ackTog(ackTog),
    .retUnder(retUnder)
  );

  pixfifo_store #(.DATA_W(DATA_W)) u_store (
    .clk(busClk), .rst_n(busRst_n), .st(st), .wrData(wrData), .retData(retData)
  );

  pixfifo_pixside #(.DATA_W(DATA_W)) u_pix (
    .clk(pixClk), .rst_n(pixRst_n), .rdReq(rdReq), .rdPanel(rdPanel),
    .irqClear(irqClear), .ackTogIn(ackTog), .retUnderIn(retUnder),
    .retDataIn(retData), .reqTog(reqTog), .reqPanel(reqPanel),
    .rdReady(rdReady), .rdValid(rdValid), .rdData(rdData),
    .underflowIrq(underflowIrq)
  );
endmodule

// File: tb/sim_dual_pixel_fifo.sv
`timescale 1ns/1ps
module sim_dual_pixel_fifo;
  logic busClk = 0, pixClk = 0, busRst_n = 0, pixRst_n = 0;
  logic flush = 0, cascadeIn = 0, wrEn = 0, wrPanel = 0;
  logic [31:0] wrData = '0;
  logic rdReq = 0, rdPanel = 0, irqClear = 0;
  logic [1:0] spaceReq;
  logic wrBusy, rdReady, rdValid, underflowIrq;
  logic [31:0] rdData;

  always #10 busClk = ~busClk;   // 50 MHz
  always #13 pixClk = ~pixClk;

  dual_pixel_fifo u0 (
    .busClk(busClk), .busRst_n(busRst_n), .pixClk(pixClk), .pixRst_n(pixRst_n),
    .flush(flush), .cascadeIn(cascadeIn), .wrEn(wrEn), .wrPanel(wrPanel),
    .wrData(wrData), .spaceReq(spaceReq), .wrBusy(wrBusy), .rdReq(rdReq),
    .rdPanel(rdPanel), .irqClear(irqClear), .rdReady(rdReady), .rdValid(rdValid),
    .rdData(rdData), .underflowIrq(underflowIrq)
  );

  int errors = 0, checks = 0;
  bit casMode = 0, busySeen = 0, finished = 0;
  logic [31:0] mq0[$], mq1[$], expQ[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compares every returned word with the scoreboard
  always @(negedge pixClk) begin
    if (rdValid) begin
      if (expQ.size() == 0) chk(0, "R8 unexpected rdValid", rdData, 32'h0);
      else begin
        logic [31:0] e;
        e = expQ.pop_front();
        chk(rdData === e, "R1/R2 read data order", rdData, e);
      end
    end
  end

  always @(negedge busClk) if (wrBusy) busySeen = 1;

  task automatic doFlush(input bit cas);
    @(negedge busClk); flush = 1; cascadeIn = cas;
    @(negedge busClk); flush = 0;
    mq0.delete(); mq1.delete(); casMode = cas;
  endtask

  task automatic doWrite(input bit panel, input logic [31:0] d);
    int cap;
    bit sel;
    sel = casMode ? 1'b0 : panel;
    cap = casMode ? 32 : 16;
    @(negedge busClk);
    while (wrBusy) @(negedge busClk);
    wrEn = 1; wrPanel = panel; wrData = d;
    @(negedge busClk); wrEn = 0;
    if (sel == 0) begin if (mq0.size() < cap) mq0.push_back(d); end
    else begin if (mq1.size() < cap) mq1.push_back(d); end
  endtask

  task automatic doRead(input bit panel, input string req);
    bit sel, expUnder;
    sel = casMode ? 1'b0 : panel;
    expUnder = 0;
    @(negedge pixClk);
    while (!rdReady) @(negedge pixClk);
    if (sel == 0) begin
      if (mq0.size() == 0) expUnder = 1; else expQ.push_back(mq0.pop_front());
    end else begin
      if (mq1.size() == 0) expUnder = 1; else expQ.push_back(mq1.pop_front());
    end
    rdReq = 1; rdPanel = panel;
    @(negedge pixClk); rdReq = 0;
    while (!rdReady) @(negedge pixClk);
    repeat (2) @(negedge pixClk);
    if (expUnder) chk(underflowIrq === 1'b1, {req, " R5 underflow irq"}, 32'(underflowIrq), 32'h1);
  endtask

  task automatic clearIrq();
    @(negedge pixClk); irqClear = 1;
    @(negedge pixClk); irqClear = 0;
    chk(underflowIrq === 1'b0, "R6 irq cleared", 32'(underflowIrq), 32'h0);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge busClk);
    busRst_n = 1; pixRst_n = 1;
    @(negedge busClk);
    // reset state
    chk(spaceReq === 2'b11, "R4 reset flags", 32'(spaceReq), 32'h3);
    chk(underflowIrq === 1'b0, "R5 reset irq", 32'(underflowIrq), 32'h0);
    chk(rdReady === 1'b1, "R8 reset ready", 32'(rdReady), 32'h1);
    chk(wrBusy === 1'b0, "R9 idle busy", 32'(wrBusy), 32'h0);

    // R1: independent dual-panel FIFOs
    for (int i = 0; i < 3; i++) doWrite(0, 32'hA000_0000 + i);
    for (int i = 0; i < 2; i++) doWrite(1, 32'hB000_0000 + i);
    busySeen = 0;
    doRead(1, "R1");
    chk(busySeen, "R9 busy seen during read", 32'(busySeen), 32'h1);
    doRead(0, "R1"); doRead(0, "R1"); doRead(1, "R1"); doRead(0, "R1");
    doRead(1, "R1");  // panel 1 now empty
    clearIrq();

    // R4 / R3 thresholds and full in dual mode
    for (int i = 0; i < 12; i++) doWrite(0, 32'hC000_0000 + i);
    chk(spaceReq === 2'b11, "R4 four free", 32'(spaceReq), 32'h3);
    doWrite(0, 32'hC000_000C);
    chk(spaceReq === 2'b10, "R4 three free", 32'(spaceReq), 32'h2);
    for (int i = 13; i < 17; i++) doWrite(0, 32'hC000_0000 + i);  // last one dropped
    chk(mq0.size() == 16, "R3 model depth", 32'(mq0.size()), 32'd16);
    for (int i = 0; i < 17; i++) doRead(0, "R3");
    clearIrq();

    // R2 cascade mode
    doFlush(1);
    chk(spaceReq === 2'b01, "R7 cascade flags after flush", 32'(spaceReq), 32'h1);
    for (int i = 0; i < 28; i++) doWrite(i[0], 32'hD000_0000 + i);
    chk(spaceReq === 2'b01, "R4 cascade four free", 32'(spaceReq), 32'h1);
    doWrite(1, 32'hD000_001C);
    chk(spaceReq === 2'b00, "R4 cascade three free", 32'(spaceReq), 32'h0);
    for (int i = 29; i < 33; i++) doWrite(0, 32'hD000_0000 + i);  // last dropped, R3
    for (int i = 0; i < 33; i++) doRead(i[0], "R2");
    clearIrq();

    // R7: mode input ignored without flush
    @(negedge busClk); cascadeIn = 0;
    for (int i = 0; i < 20; i++) doWrite(i[0], 32'hE000_0000 + i);
    chk(spaceReq === 2'b01, "R7 mode held without flush", 32'(spaceReq), 32'h1);
    doRead(1, "R2"); doRead(1, "R2");
    doFlush(0);
    chk(spaceReq === 2'b11, "R7 flush to dual", 32'(spaceReq), 32'h3);
    doRead(0, "R7 flushed");
    clearIrq();

    repeat (6) @(negedge pixClk);
    chk(expQ.size() == 0, "R8 all words returned", 32'(expQ.size()), 32'h0);
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule